// File: doc/BRIEF.md
# Six-Channel Pulse-Width Modulator with Pair Joining

This block produces six 8-bit pulse-width modulated outputs from one system clock. A single prescaler divides the clock into a channel tick, and every channel advances its counter once per tick. Each channel has a period byte, a duty byte, an enable bit and its own output pin. Software programs the block through a small byte-wide register port with a combinational read path.

Adjacent channels can be joined into a 16-bit channel. The pairs are (0,1), (2,3) and (4,5). In a joined pair, the even channel supplies the upper byte of the period and duty values, and the odd channel supplies the lower byte. The odd channel's enable bit alone starts and stops the pair. The 16-bit waveform appears on the odd output, and the even output is held low.

A newly set enable bit arms its channel at once. The waveform itself starts only on the next prescaler tick, so the first period can be short. When every enable bit is clear, the prescaler is held at zero so that it does not toggle.

Top module: `pwm6_cat`

## Requirements
- R1: After reset, every register reads 0 and all six outputs are low.
- R2: Register map, by byte address:
  - 0x0 is the enable register: bit i enables channel i, and bits 7..6 read as 0.
  - 0x1 is the join register: bit 0 joins channels 0/1, bit 1 joins 2/3 and bit 2 joins 4/5. Bits 7..3 read as 0.
  - 0x2+i is the period byte of channel i, and 0x8+i is its duty byte.
  - All registers can be written at any time and read back.
- R3: An unjoined running channel steps its count through 0 to period-1, one step per prescaler tick, and then wraps to 0. Its output is high while the count is below the duty value.
- R4: The prescaler divides by PRESC_DIV (default 4). While all enable bits are 0 it is held at zero. Consequently, the first enable written while all channels are off makes the output rise exactly PRESC_DIV clock edges after the write edge.
- R5: A channel enabled while the prescaler is already running starts from count 0 at the first prescaler tick edge after the write edge.
- R6: Clearing an enable bit stops its channel and drives the output low from the first clock edge after the write edge. The count is cleared, so a later enable starts again from count 0.
- R7: In a joined pair, one 16-bit counter runs against the period {even byte, odd byte} and the duty {even byte, odd byte}. It is enabled by the odd bit, and its waveform is driven on the odd output.
- R8: In a joined pair, the even channel's output stays low and its enable bit has no effect. Setting only the even bit leaves both outputs low.
- R9: A channel whose enable bit is 0 drives a constant low, whatever its period and duty bytes hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (4) | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pwm_out | output | NCH (6) | Channel outputs |

## Verification
Output waveforms are compared cycle by cycle against a model that works out each channel's start edge and its count from the tick arithmetic.

Several patterns are used, and each separates different faults:
- Starting from an all-off state tells a halted prescaler from a free-running one, because only the halted prescaler gives a fixed start edge.
- Enabling a second channel while the first runs exposes whether the start waits for the next tick or starts at the write edge.
- Disabling and then re-enabling a channel shows whether its count was cleared.
- A joined pair with a 258-tick period and a 256-tick duty can only match if all sixteen bits take part. Also setting the even enable bit during this run shows whether that output is gated.
- Disabled channels are loaded with duty bytes that would drive them high if they ran.

// File: rtl/pwm6_pkg.sv
package pwm6_pkg;

  localparam int BYTE_W = 8;

  // Address map offsets (the enable register sits at zero)
  localparam int ADDR_EN    = 0;
  localparam int ADDR_JOIN  = 1;
  localparam int PER_BASE   = 2;

  function automatic int duty_base(input int nch);
    return PER_BASE + nch;
  endfunction

  function automatic int addr_width(input int nch);
    return $clog2(PER_BASE + 2 * nch);
  endfunction

  // Next count value: wraps to zero once period reached; a zero period
  // wraps at the natural width of the counter.
  function automatic logic [15:0] next_count(input logic [15:0] cur,
                                             input logic [15:0] per,
                                             input logic        wide);
    logic [15:0] nxt;
    nxt = cur + 16'd1;
    if (!wide) nxt[15:8] = 8'h00;
    if ((per != 16'h0000) && (nxt >= per)) nxt = 16'h0000;
    return nxt;
  endfunction

  // Output level for a running channel
  function automatic logic duty_hit(input logic [15:0] cur,
                                    input logic [15:0] duty);
    return cur < duty;
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_en,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (!any_en) begin
      pcnt <= '0;
    end else if (pcnt == LAST) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

  assign tick = any_en && (pcnt == LAST);

  AST_PRESC_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    !any_en |=> (pcnt == '0)); // R4

  generate
    if (DIV > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R4
    end
  endgenerate

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm6_pkg::*;
#(
  parameter int NPAIR = 3,
  localparam int NCH = 2 * NPAIR,
  localparam int AW  = addr_width(2 * NPAIR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [NCH-1:0]    en_q,
  output logic [NPAIR-1:0]  join_q,
  output logic [BYTE_W-1:0] per_q  [NCH],
  output logic [BYTE_W-1:0] duty_q [NCH]
);
  localparam int DUTY_BASE = duty_base(NCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      join_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        per_q[i]  <= '0;
        duty_q[i] <= '0;
      end
    end else if (we) begin
      if (int'(addr) == ADDR_EN)   en_q   <= wdata[NCH-1:0];
      if (int'(addr) == ADDR_JOIN) join_q <= wdata[NPAIR-1:0];
      for (int i = 0; i < NCH; i++) begin
        if (int'(addr) == PER_BASE + i)  per_q[i]  <= wdata;
        if (int'(addr) == DUTY_BASE + i) duty_q[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (int'(addr) == ADDR_EN)   rdata[NCH-1:0]   = en_q;
    if (int'(addr) == ADDR_JOIN) rdata[NPAIR-1:0] = join_q;
    for (int i = 0; i < NCH; i++) begin
      if (int'(addr) == PER_BASE + i)  rdata = per_q[i];
      if (int'(addr) == DUTY_BASE + i) rdata = duty_q[i];
    end
  end

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(addr) == ADDR_EN) |=> (en_q == $past(wdata[NCH-1:0]))); // R2

endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
  import pwm6_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              joined,
  input  logic              en_hi,
  input  logic              en_lo,
  input  logic [BYTE_W-1:0] per_hi,
  input  logic [BYTE_W-1:0] per_lo,
  input  logic [BYTE_W-1:0] duty_hi,
  input  logic [BYTE_W-1:0] duty_lo,
  output logic              out_hi,
  output logic              out_lo
);
  // cnt16 is the shared counter: two 8-bit halves or one 16-bit counter
  logic [15:0] cnt16;
  logic        run_hi, run_lo;

  wire [15:0] per_w   = {per_hi, per_lo};
  wire [15:0] duty_w  = {duty_hi, duty_lo};
  wire [15:0] nxt_w   = next_count(cnt16, per_w, 1'b1);
  wire [15:0] nxt_lo  = next_count({8'h00, cnt16[7:0]},  {8'h00, per_lo}, 1'b0);
  wire [15:0] nxt_hi  = next_count({8'h00, cnt16[15:8]}, {8'h00, per_hi}, 1'b0);

  // named events for the checks
  wire start_lo = en_lo && tick && !run_lo;
  wire start_hi = !joined && en_hi && tick && !run_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt16  <= '0;
      run_hi <= 1'b0;
      run_lo <= 1'b0;
    end else if (joined) begin
      run_hi <= 1'b0;
      if (!en_lo) begin
        run_lo <= 1'b0;
        cnt16  <= '0;
      end else if (tick) begin
        run_lo <= 1'b1;
        cnt16  <= run_lo ? nxt_w : 16'h0000;
      end
    end else begin
      if (!en_lo) begin
        run_lo      <= 1'b0;
        cnt16[7:0]  <= '0;
      end else if (tick) begin
        run_lo      <= 1'b1;
        cnt16[7:0]  <= run_lo ? nxt_lo[7:0] : 8'h00;
      end
      if (!en_hi) begin
        run_hi      <= 1'b0;
        cnt16[15:8] <= '0;
      end else if (tick) begin
        run_hi      <= 1'b1;
        cnt16[15:8] <= run_hi ? nxt_hi[7:0] : 8'h00;
      end
    end
  end

  wire lvl_w  = duty_hit(cnt16, duty_w);
  wire lvl_lo = duty_hit({8'h00, cnt16[7:0]},  {8'h00, duty_lo});
  wire lvl_hi = duty_hit({8'h00, cnt16[15:8]}, {8'h00, duty_hi});

  assign out_lo = run_lo && (joined ? lvl_w : lvl_lo);
  assign out_hi = !joined && run_hi && lvl_hi;

  AST_HI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    joined |=> !run_hi); // R8
  AST_LO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !en_lo |=> !run_lo); // R6
  AST_LO_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    start_lo |=> (cnt16[7:0] == 8'h00)); // R5
  AST_HI_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    start_hi |=> (cnt16[15:8] == 8'h00)); // R5

endmodule

// File: rtl/pwm6_cat.sv
module pwm6_cat
  import pwm6_pkg::*;
#(
  parameter int NPAIR     = 3,
  parameter int PRESC_DIV = 4,
  localparam int NCH = 2 * NPAIR,
  localparam int AW  = addr_width(2 * NPAIR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic [NCH-1:0]    pwm_out
);
  logic [NCH-1:0]    en_q;
  logic [NPAIR-1:0]  join_q;
  logic [BYTE_W-1:0] per_q  [NCH];
  logic [BYTE_W-1:0] duty_q [NCH];
  logic              tick;
  wire               any_en = |en_q;

  pwm_regs #(.NPAIR(NPAIR)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .en_q(en_q), .join_q(join_q),
    .per_q(per_q), .duty_q(duty_q)
  );

  pwm_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .any_en(any_en), .tick(tick)
  );

  // even channel = upper byte, odd channel = lower byte and pair output
  generate
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      pwm_pair u_pair (
        .clk(clk), .rst_n(rst_n), .tick(tick), .joined(join_q[p]),
        .en_hi(en_q[2*p]), .en_lo(en_q[2*p+1]),
        .per_hi(per_q[2*p]), .per_lo(per_q[2*p+1]),
        .duty_hi(duty_q[2*p]), .duty_lo(duty_q[2*p+1]),
        .out_hi(pwm_out[2*p]), .out_lo(pwm_out[2*p+1])
      );
    end
  endgenerate

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> (pwm_out == '0)); // R9

endmodule

// File: tb/pwm6_cat_tb.sv
module pwm6_cat_tb;
  localparam int P    = 4;
  localparam int NCH  = 6;
  localparam int INF  = 1 << 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [5:0] pwm_out;

  int errors = 0;
  int checks = 0;
  int edge_n = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz
  always @(posedge clk) edge_n <= edge_n + 1;

  pwm6_cat u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  typedef struct {
    int    n;
    int    ch;
    bit    exp;
    string req;
  } item_t;
  item_t sb[$];

  // channel model: start edge, period, duty, requirement tag
  int    m_s    [NCH];
  int    m_per  [NCH];
  int    m_duty [NCH];
  string m_req  [NCH];

  function automatic bit model_level(int n, int ch);
    int t;
    if (n < m_s[ch]) return 1'b0;
    t = (n - m_s[ch]) / P;
    return ((t % m_per[ch]) < m_duty[ch]);
  endfunction

  task automatic push_edges(int from, int to);
    for (int n = from; n <= to; n++)
      for (int c = 0; c < NCH; c++)
        if (m_req[c] != "") begin
          item_t it;
          it.n = n; it.ch = c; it.exp = model_level(n, c); it.req = m_req[c];
          sb.push_back(it);
        end
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0 && sb[0].n <= edge_n) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (it.n != edge_n || pwm_out[it.ch] !== it.exp) begin
          errors++;
          $display("FAIL %s edge %0d ch%0d: actual=%b expected=%b",
                   it.req, it.n, it.ch, pwm_out[it.ch], it.exp);
        end
      end
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, int exp, string req);
    @(negedge clk);
    reg_addr = 4'(a);
    #1;
    checks++;
    if (reg_rdata !== 8'(exp)) begin
      errors++;
      $display("FAIL %s read 0x%0h: actual=0x%0h expected=0x%0h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic check_out(int exp, string req);
    #1;
    checks++;
    if (pwm_out !== 6'(exp)) begin
      errors++;
      $display("FAIL %s outputs: actual=0x%0h expected=0x%0h", req, pwm_out, exp);
    end
  endtask

  task automatic unwatch();
    for (int c = 0; c < NCH; c++) begin
      m_s[c] = INF; m_per[c] = 1; m_duty[c] = 0; m_req[c] = "";
    end
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int e, s0, s2;
    unwatch();
    repeat (3) @(negedge clk);
    // R1: reset state
    check_out(0, "R1");
    rd(0, 0, "R1");
    rd(1, 0, "R1");
    rd(5, 0, "R1");
    rd(13, 0, "R1");
    rst_n = 1'b1;

    // R2: register map and unimplemented bits
    wr(0, 'hFF); rd(0, 'h3F, "R2");
    wr(0, 'h00); rd(0, 'h00, "R2");
    wr(1, 'hFF); rd(1, 'h07, "R2");
    wr(1, 'h00); rd(1, 'h00, "R2");
    wr(5, 'hA5); rd(5, 'hA5, "R2");
    wr(11, 'h3C); rd(11, 'h3C, "R2");
    repeat (3) @(negedge clk);

    // R3/R4: first enable from all-off, prescaler halted
    wr(2, 5); wr(8, 2);           // ch0 period 5, duty 2
    wr(3, 4); wr(9, 'hFF);        // ch1 would be high if it ran (R9)
    repeat (3) @(negedge clk);
    wr(0, 'h01); e = edge_n;
    s0 = e + P;
    m_s[0] = s0; m_per[0] = 5; m_duty[0] = 2; m_req[0] = "R4/R3";
    m_req[1] = "R9";
    push_edges(e + 1, e + 60);
    drain();

    // R5: second channel enabled while prescaler runs
    wr(4, 3); wr(10, 1);          // ch2 period 3, duty 1
    repeat (5) @(negedge clk);
    wr(0, 'h05); e = edge_n;
    s2 = s0 + P * ((e - s0) / P + 1);
    m_req[0] = "R3";
    m_s[2] = s2; m_per[2] = 3; m_duty[2] = 1; m_req[2] = "R5";
    push_edges(e + 1, e + 48);
    drain();

    // R6: disable stops at next edge, re-enable restarts from count 0
    @(negedge clk);
    wr(0, 'h01); e = edge_n;
    m_s[2] = INF; m_req[2] = "R6";
    push_edges(e + 1, e + 21);
    drain();
    @(negedge clk);
    wr(0, 'h05); e = edge_n;
    m_s[2] = s0 + P * ((e - s0) / P + 1); m_req[2] = "R6";
    push_edges(e + 1, e + 36);
    drain();

    // R7/R8: joined pair 4/5 with 16-bit period 0x0102 and duty 0x0100
    wr(0, 'h00);
    unwatch();
    wr(6, 'h01); wr(7, 'h02);
    wr(12, 'h01); wr(13, 'h00);
    wr(1, 'h04);
    repeat (2) @(negedge clk);
    wr(0, 'h30); e = edge_n;       // both bits; even one must be ignored
    m_s[5] = e + P; m_per[5] = 258; m_duty[5] = 256; m_req[5] = "R7";
    m_req[4] = "R8";
    push_edges(e + 1, e + 258 * P + 40);
    drain();

    // R8: only the even bit of a joined pair set
    wr(0, 'h10); e = edge_n;
    m_s[5] = INF; m_req[5] = "R8";
    push_edges(e + 1, e + 40);
    drain();

    // R9: everything off
    wr(0, 'h00);
    @(negedge clk);
    check_out(0, "R9");
    finish_run();
  end

endmodule